// File: doc/BRIEF.md
# DDR Extended Mode Register Sequencer

This controller-side block programs the extended mode register of a DDR SDRAM on request. After reset, or after a finished sequence, it waits for a start pulse and latches the requested DLL state and output drive choice. It then waits until the memory reports every bank idle with no burst running. At that point it issues an extended LOAD MODE REGISTER. When the DLL is being enabled, it follows that load with a base LOAD MODE REGISTER that asks for a DLL reset. Between commands it drives NOP and keeps a programmable spacing.

While a sequence runs, the read-permit output is held low. When the DLL was enabled, it stays low until the lock interval, counted from the extended load, has run out. When the sequence only disables the DLL, there is no DLL-reset load and no lock wait. A one-cycle done pulse marks completion. A start request that arrives during a sequence is dropped and sets a sticky error flag.

Top module: `ddr_emr_seq`

## Requirements
- R1: A start pulse in the idle state is accepted. The extended load is issued in the cycle after the first clock edge at which `banks_idle_i` is sampled high. Until then only NOP is driven.
- R2: The extended load is encoded as command pins {cs,ras,cas,we} = 4'b0000 with `ba_o` = 2'b01. Address bits ADDR_W-1 down to 2 are zero. Address bit 0 is the inverse of the latched DLL-enable request (0 = enable, 1 = disable).
- R3: Address bit 1 of the extended load equals the latched reduced-drive request when the X16 parameter is 1, and is always 0 when X16 is 0.
- R4: Only two command codes ever appear on the pins: LOAD MODE REGISTER (4'b0000) and NOP (4'b0111). NOP is driven in every cycle that carries no load, including reset.
- R5: After each load exactly `load_gap_i`+1 NOP cycles pass before the next command or completion, with `load_gap_i` sampled in the load cycle.
- R6: With the DLL enabled, the second load follows the extended load by `load_gap_i`+2 cycles. It carries `ba_o` = 2'b00 and address BASE_MODE with bit DLL_RST_BIT forced to 1.
- R7: With the DLL disabled, no second load is issued. `read_permit_o` and `done_o` rise `load_gap_i`+2 cycles after the extended load.
- R8: With the DLL enabled, `read_permit_o` first rises exactly LOCK_CYCLES cycles after the extended load cycle. It is low in every cycle in which `busy_o` is high.
- R9: `done_o` is high for exactly one cycle, in the cycle in which `read_permit_o` rises. `busy_o` is high from the cycle after acceptance until that cycle.
- R10: A start pulse while `busy_o` is high does not change the running sequence. It sets `err_o`, which stays high until reset.
- R11: In reset, and right after it, the pins carry NOP, and `busy_o`, `done_o`, `read_permit_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sequence request pulse |
| dll_on_i | input | 1 | 1 = enable DLL, 0 = disable |
| drv_low_i | input | 1 | 1 = request reduced output drive |
| banks_idle_i | input | 1 | All banks idle, no burst in progress |
| load_gap_i | input | GAP_W | NOP cycles after each load, minus one |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| read_permit_o | output | 1 | READ commands allowed |
| err_o | output | 1 | Sticky start-while-busy flag |

## Verification
All results are counted from the start acceptance edge. The extended load appears `d`+2 cycles after acceptance, where `d` is the number of cycles `banks_idle_i` is held low. The second load follows `load_gap_i`+2 cycles after the extended load. Completion comes either `load_gap_i`+2 or LOCK_CYCLES cycles after the extended load, depending on the DLL choice. At every falling edge the bench compares the pins, `busy_o`, `done_o` and `read_permit_o` with the values expected for that cycle index. Those values are computed from `d`, `load_gap_i` and the DLL choice, so a shift of one cycle in any result shows up as a mismatch.

// File: rtl/ddr_emr_pkg.sv
`timescale 1ns/1ps
package ddr_emr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_EMR, ST_GAP1, ST_MRS, ST_GAP2, ST_LOCK
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t CMD_NOP = cmd_pins_t'(4'b0111);
  localparam cmd_pins_t CMD_LMR = cmd_pins_t'(4'b0000);
  localparam logic [1:0] BA_BASE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b01;
endpackage

// File: rtl/ddr_emr_gap_timer.sv
`timescale 1ns/1ps
module ddr_emr_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_emr_lock_timer.sv
`timescale 1ns/1ps
module ddr_emr_lock_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic reached_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // clear cycle counts as the first lock cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clear_i)     cnt_q <= CW'(1);
    else if (cnt_q < TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q >= TOP);
endmodule

// File: rtl/ddr_emr_cmd_enc.sv
`timescale 1ns/1ps
module ddr_emr_cmd_enc
  import ddr_emr_pkg::*;
#(
  parameter int                 ADDR_W      = 13,
  parameter bit                 X16         = 1'b1,
  parameter logic [ADDR_W-1:0]  BASE_MODE   = 'h022,
  parameter int                 DLL_RST_BIT = 8
) (
  input  seq_state_e        state_i,
  input  logic              dll_on_i,
  input  logic              drv_low_i,
  output cmd_pins_t         cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] MRS_WORD = BASE_MODE | (ADDR_W'(1) << DLL_RST_BIT);

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = BA_BASE;
    addr_o = '0;
    case (state_i)
      ST_EMR: begin
        cmd_o     = CMD_LMR;
        ba_o      = BA_EXT;
        addr_o[0] = ~dll_on_i;
        addr_o[1] = drv_low_i & X16;
      end
      ST_MRS: begin
        cmd_o  = CMD_LMR;
        ba_o   = BA_BASE;
        addr_o = MRS_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_emr_seq.sv
`timescale 1ns/1ps
module ddr_emr_seq
  import ddr_emr_pkg::*;
#(
  parameter int                ADDR_W      = 13,
  parameter int                GAP_W       = 4,
  parameter int                LOCK_CYCLES = 200,
  parameter bit                X16         = 1'b1,
  parameter logic [ADDR_W-1:0] BASE_MODE   = 'h022,
  parameter int                DLL_RST_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dll_on_i,
  input  logic              drv_low_i,
  input  logic              banks_idle_i,
  input  logic [GAP_W-1:0]  load_gap_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              read_permit_o,
  output logic              err_o
);
  seq_state_e state_q, state_d;
  logic dll_q, drv_q, permit_q, done_q, err_q;
  logic gap_exp, lock_reached, accept, finish;
  cmd_pins_t cmd;

  ddr_emr_gap_timer #(.W(GAP_W)) gap_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_EMR || state_q == ST_MRS),
    .val_i     (load_gap_i),
    .expired_o (gap_exp)
  );

  ddr_emr_lock_timer #(.LIMIT(LOCK_CYCLES)) lock_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q == ST_EMR),
    .reached_o (lock_reached)
  );

  ddr_emr_cmd_enc #(
    .ADDR_W(ADDR_W), .X16(X16), .BASE_MODE(BASE_MODE), .DLL_RST_BIT(DLL_RST_BIT)
  ) enc_i (
    .state_i   (state_q),
    .dll_on_i  (dll_q),
    .drv_low_i (drv_q),
    .cmd_o     (cmd),
    .ba_o      (ba_o),
    .addr_o    (addr_o)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i)      state_d = ST_WAIT;
      ST_WAIT: if (banks_idle_i) state_d = ST_EMR;
      ST_EMR:                    state_d = ST_GAP1;
      ST_GAP1: if (gap_exp)      state_d = dll_q ? ST_MRS : ST_IDLE;
      ST_MRS:                    state_d = ST_GAP2;
      ST_GAP2: if (gap_exp)      state_d = ST_LOCK;
      ST_LOCK: if (lock_reached) state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  assign accept = (state_q == ST_IDLE) && start_i;
  assign finish = ((state_q == ST_GAP1) && gap_exp && !dll_q) ||
                  ((state_q == ST_LOCK) && lock_reached);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dll_q    <= 1'b0;
      drv_q    <= 1'b0;
      permit_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (accept) begin
        dll_q    <= dll_on_i;
        drv_q    <= drv_low_i;
        permit_q <= 1'b0;
      end else if (finish) begin
        permit_q <= 1'b1;
      end
      if (start_i && state_q != ST_IDLE) err_q <= 1'b1;
    end
  end

  assign cs_no         = cmd.cs_n;
  assign ras_no        = cmd.ras_n;
  assign cas_no        = cmd.cas_n;
  assign we_no         = cmd.we_n;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign read_permit_o = permit_q;
  assign err_o         = err_q;
endmodule

// File: rtl/ddr_emr_seq_chk.sv
`timescale 1ns/1ps
module ddr_emr_seq_chk #(
  parameter int ADDR_W      = 13,
  parameter bit X16         = 1'b1,
  parameter int LOCK_CYCLES = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              banks_idle_i,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              read_permit_o,
  input logic              err_o
);
  localparam int SW = $clog2(LOCK_CYCLES + 1);

  logic is_lmr, is_nop, is_emr;
  logic [SW-1:0] since_q;
  logic armed_q;

  assign is_lmr = ({cs_no, ras_no, cas_no, we_no} == 4'b0000);
  assign is_nop = ({cs_no, ras_no, cas_no, we_no} == 4'b0111);
  assign is_emr = is_lmr && (ba_o == 2'b01);

  // cycles since the last DLL-enabling extended load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      armed_q <= 1'b0;
    end else if (is_emr) begin
      since_q <= SW'(1);
      armed_q <= ~addr_o[0];
    end else if (since_q < SW'(LOCK_CYCLES)) begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r4_legal_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr || is_nop);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_emr |-> (addr_o[ADDR_W-1:2] == '0));
  a_r3_drive_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_emr && !X16) |-> !addr_o[1]);
  a_r1_idle_before_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_emr |-> $past(banks_idle_i));
  a_r5_nop_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lmr |=> is_nop);
  a_r8_lock_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(read_permit_o) && armed_q) |-> (since_q >= SW'(LOCK_CYCLES)));
  a_r8_blocked_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !read_permit_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(read_permit_o));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind ddr_emr_seq ddr_emr_seq_chk #(
  .ADDR_W(ADDR_W), .X16(X16), .LOCK_CYCLES(LOCK_CYCLES)
) chk_i (.*);

// File: tb/ddr_emr_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_emr_seq_tb_top;
  localparam int          ADDR_W  = 13;
  localparam int          GAP_W   = 4;
  localparam int          LOCK    = 200;
  localparam logic [12:0] BASE    = 13'h022;
  localparam int          RST_BIT = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, dll_on_i = 1'b0, drv_low_i = 1'b0, banks_idle_i = 1'b0;
  logic [GAP_W-1:0] load_gap_i = '0;
  logic cs_no, ras_no, cas_no, we_no, busy_o, done_o, read_permit_o, err_o;
  logic [1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic n_cs, n_ras, n_cas, n_we, n_busy, n_done, n_permit, n_err;
  logic [1:0] n_ba;
  logic [ADDR_W-1:0] n_addr;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ddr_emr_seq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .LOCK_CYCLES(LOCK), .X16(1'b1),
                .BASE_MODE(BASE), .DLL_RST_BIT(RST_BIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dll_on_i(dll_on_i),
    .drv_low_i(drv_low_i), .banks_idle_i(banks_idle_i), .load_gap_i(load_gap_i),
    .cs_no(cs_no), .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no),
    .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o),
    .read_permit_o(read_permit_o), .err_o(err_o));

  ddr_emr_seq #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .LOCK_CYCLES(LOCK), .X16(1'b0),
                .BASE_MODE(BASE), .DLL_RST_BIT(RST_BIT)) dut_n16 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .dll_on_i(dll_on_i),
    .drv_low_i(drv_low_i), .banks_idle_i(banks_idle_i), .load_gap_i(load_gap_i),
    .cs_no(n_cs), .ras_no(n_ras), .cas_no(n_cas), .we_no(n_we),
    .ba_o(n_ba), .addr_o(n_addr), .busy_o(n_busy), .done_o(n_done),
    .read_permit_o(n_permit), .err_o(n_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins();
    return {cs_no, ras_no, cas_no, we_no};
  endfunction

  task automatic check_reset_state();
    chk(pins() == 4'b0111, "R11", "reset cmd", 32'(pins()), 32'h7);
    chk(busy_o == 1'b0, "R11", "reset busy", 32'(busy_o), 0);
    chk(done_o == 1'b0, "R11", "reset done", 32'(done_o), 0);
    chk(read_permit_o == 1'b0, "R11", "reset permit", 32'(read_permit_o), 0);
    chk(err_o == 1'b0, "R11", "reset err", 32'(err_o), 0);
  endtask

  // d: cycles banks_idle stays low after acceptance; poke: stray start mid-run
  task automatic run_seq(input bit dll, input bit drv, input int g, input int d, input bit poke);
    int e_cyc, m_cyc, p_cyc;
    logic [12:0] emr_exp, emr_n16, mrs_exp;
    logic [3:0] exp_cmd;
    @(negedge clk);
    dll_on_i = dll; drv_low_i = drv; load_gap_i = GAP_W'(g);
    banks_idle_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    e_cyc   = d + 2;
    m_cyc   = e_cyc + g + 2;
    p_cyc   = dll ? e_cyc + LOCK : e_cyc + g + 2;
    emr_exp = {11'b0, drv, ~dll};
    emr_n16 = {11'b0, 1'b0, ~dll};
    mrs_exp = BASE | (13'd1 << RST_BIT);
    for (int n = 1; n <= p_cyc; n++) begin
      if (n > 1) @(negedge clk);
      exp_cmd = (n == e_cyc || (dll && n == m_cyc)) ? 4'b0000 : 4'b0111;
      // R1 R4 R5 R6 R7: command stream timing
      chk(pins() == exp_cmd, "R5", $sformatf("cmd n=%0d", n), 32'(pins()), 32'(exp_cmd));
      if (n == e_cyc) begin
        chk(ba_o == 2'b01, "R2", "ext bank", 32'(ba_o), 1);
        chk(addr_o == emr_exp, "R2", "ext addr", 32'(addr_o), 32'(emr_exp));
        chk(n_addr == emr_n16, "R3", "ext addr no-x16", 32'(n_addr), 32'(emr_n16));
      end
      if (dll && n == m_cyc) begin
        chk(ba_o == 2'b00, "R6", "base bank", 32'(ba_o), 0);
        chk(addr_o == mrs_exp, "R6", "base addr", 32'(addr_o), 32'(mrs_exp));
      end
      chk(read_permit_o == (n == p_cyc), dll ? "R8" : "R7",
          $sformatf("permit n=%0d", n), 32'(read_permit_o), 32'(n == p_cyc));
      chk(done_o == (n == p_cyc), "R9", $sformatf("done n=%0d", n), 32'(done_o), 32'(n == p_cyc));
      chk(busy_o == (n < p_cyc), "R9", $sformatf("busy n=%0d", n), 32'(busy_o), 32'(n < p_cyc));
      banks_idle_i = (n > d);
      if (poke) start_i = (n == 3);
    end
    if (poke) chk(err_o == 1'b1, "R10", "err after stray start", 32'(err_o), 1);
  endtask

  initial begin
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state();
    for (int dl = 0; dl < 2; dl++)
      for (int dv = 0; dv < 2; dv++)
        for (int gi = 0; gi < 4; gi++)
          for (int di = 0; di < 2; di++)
            run_seq(dl[0], dv[0], (gi == 3) ? 15 : gi, di * 2, 1'b0);
    chk(err_o == 1'b0, "R10", "no err without stray start", 32'(err_o), 0);
    run_seq(1'b1, 1'b0, 2, 1, 1'b1);
    run_seq(1'b0, 1'b1, 0, 0, 1'b1);
    @(negedge clk);
    chk(err_o == 1'b1, "R10", "err still set", 32'(err_o), 1);
    chk(read_permit_o == 1'b1, "R8", "permit held in idle", 32'(read_permit_o), 1);
    rst_ni = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_ni = 1'b1;
    @(negedge clk);
    check_reset_state();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule